// File: doc/BRIEF.md
# Dual-Edge GPIO Interrupt Controller

This block watches a small group of general-purpose pins and turns their transitions into two active-low interrupt requests, one for power management and one for system management. Each pin can be placed in a dual-edge mode. In that mode both a rising and a falling transition count as an event, and the pin works purely as an input. Outside that mode the pin is an ordinary GPIO with a direction, an output level, an inversion bit and an open-drain option.

Every pin input passes through a synchronizer and an edge detector. A detected edge sets the pin's bit in three status registers: the power-management status, the system-management status, and a summary event status. It sets them whatever the enables and the mode are. Software clears status bits by writing ones. An interrupt line is asserted only for a pin that has its status bit set, its enable bit set and dual-edge mode selected.

A register port with a write strobe, a read strobe and a four-bit address gives access to all controls. Read data comes back one cycle after the read strobe, marked by a valid flag.

Top module: `edge_irq_gpio`

## Requirements
- R1: After reset every control register (mode, inversion, direction, open-drain, output level, both enables) and all three status registers read 0, both interrupt outputs are high and no pin output is enabled.
- R2: A rising or falling transition on a pin sets that pin's bit in the power-management status (address 7), the system-management status (address 8) and the event status (address 9) within four clock cycles. Several pins changing together set several bits.
- R3: Status bits are set on edges even when dual-edge mode and both enables are 0 for that pin.
- R4: Writing a status register clears exactly the bits written as 1. Bits written as 0 and the other two status registers are unchanged.
- R5: If an edge and a write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R6: The power-management interrupt output (active low) is asserted one cycle after some pin has its power-management status bit, its power-management enable bit (address 5) and its mode bit (address 0) all set, and it is deasserted otherwise. The system-management output follows the same rule with its own status and its enable (address 6).
- R7: For a pin in dual-edge mode the output enable is 0, whatever the direction, open-drain, inversion and output-level bits hold.
- R8: For a pin not in dual-edge mode with direction bit 1 (address 2), the drive level is the output-level bit (address 4) XOR the inversion bit (address 1). In push-pull mode the output enable is 1 and the pin output is that level. In open-drain mode (address 3 bit 1) the pin output is 0 and the output enable is 1 only when the level is 0.
- R9: Reading address 4 returns the synchronized pin values XOR the inversion bits, in dual-edge mode as well as in normal mode.
- R10: The control registers at addresses 0 through 6 read back the value last written. Read data is valid one cycle after the read strobe, with the read-valid flag high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Pad input values |
| pin_o | output | NUM_PINS | Pad output values |
| pin_oe | output | NUM_PINS | Pad output enables |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | NUM_PINS | Write data |
| reg_rdata | output | NUM_PINS | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| pm_irq_n | output | 1 | Power-management interrupt, active low |
| sm_irq_n | output | 1 | System-management interrupt, active low |

## Verification
Edges are tried as a single rising pin, a single falling pin and two pins rising together, with all enables and modes off. This separates edge capture from interrupt gating and shows that both directions register. The interrupt lines are then stepped through the enable-without-mode, mode-with-enable and cleared cases, which separates the three-way gating from the status latch itself. A clear write timed to land on the same cycle as an edge shows that set has priority. Drive checks run push-pull, open-drain and inverted levels in normal mode against dual-edge mode with every output control set.

// File: rtl/eeg_pkg.sv
`timescale 1ns/1ps
package eeg_pkg;
   localparam int REG_AW = 4;

   typedef enum logic [REG_AW-1:0] {
      A_MODE  = 4'd0,
      A_POL   = 4'd1,
      A_DIR   = 4'd2,
      A_ODRN  = 4'd3,
      A_DATA  = 4'd4,
      A_PMEN  = 4'd5,
      A_SMEN  = 4'd6,
      A_PMSTS = 4'd7,
      A_SMSTS = 4'd8,
      A_EVSTS = 4'd9
   } reg_addr_e;

   localparam int NUM_STS = 3;
endpackage

// File: rtl/eeg_sync_edge.sv
`timescale 1ns/1ps
module eeg_sync_edge #(
   parameter int NUM_PINS    = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   output logic [NUM_PINS-1:0] sync_o,
   output logic [NUM_PINS-1:0] edge_o
);
   localparam int LAST = SYNC_STAGES - 1;

   for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
      logic [SYNC_STAGES-1:0] chain_q;
      logic                   prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
         end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], pin_i[g]};
            prev_q  <= chain_q[LAST];
         end
      end

      assign sync_o[g] = chain_q[LAST];
      assign edge_o[g] = chain_q[LAST] ^ prev_q;
   end
endmodule

// File: rtl/eeg_w1c.sv
`timescale 1ns/1ps
module eeg_w1c #(
   parameter int WIDTH = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] clr_eff;

   assign clr_eff = clr_we ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr_eff) | set_i;
   end
endmodule

// File: rtl/eeg_ctrl_regs.sv
`timescale 1ns/1ps
module eeg_ctrl_regs
   import eeg_pkg::*;
#(
   parameter int NUM_PINS = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [REG_AW-1:0]   addr,
   input  logic [NUM_PINS-1:0] wdata,
   output logic [NUM_PINS-1:0] mode,
   output logic [NUM_PINS-1:0] pol,
   output logic [NUM_PINS-1:0] dir,
   output logic [NUM_PINS-1:0] odrn,
   output logic [NUM_PINS-1:0] dout,
   output logic [NUM_PINS-1:0] pmen,
   output logic [NUM_PINS-1:0] smen
);
   localparam int NUM_CTRL = 7;

   logic [NUM_PINS-1:0] ctrl_q [NUM_CTRL];

   for (genvar k = 0; k < NUM_CTRL; k++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ctrl_q[k] <= '0;
         else if (wr && (addr == REG_AW'(k)))
            ctrl_q[k] <= wdata;
      end
   end

   assign mode = ctrl_q[A_MODE];
   assign pol  = ctrl_q[A_POL];
   assign dir  = ctrl_q[A_DIR];
   assign odrn = ctrl_q[A_ODRN];
   assign dout = ctrl_q[A_DATA];
   assign pmen = ctrl_q[A_PMEN];
   assign smen = ctrl_q[A_SMEN];
endmodule

// File: rtl/eeg_pad.sv
`timescale 1ns/1ps
module eeg_pad #(
   parameter int NUM_PINS = 6
) (
   input  logic [NUM_PINS-1:0] mode,
   input  logic [NUM_PINS-1:0] pol,
   input  logic [NUM_PINS-1:0] dir,
   input  logic [NUM_PINS-1:0] odrn,
   input  logic [NUM_PINS-1:0] dout,
   output logic [NUM_PINS-1:0] pin_o,
   output logic [NUM_PINS-1:0] pin_oe
);
   for (genvar g = 0; g < NUM_PINS; g++) begin : g_drv
      logic lvl;
      logic drive;

      assign lvl   = dout[g] ^ pol[g];
      assign drive = dir[g] & ~mode[g];

      always_comb begin
         if (odrn[g]) begin
            pin_o[g]  = 1'b0;
            pin_oe[g] = drive & ~lvl;
         end else begin
            pin_o[g]  = lvl;
            pin_oe[g] = drive;
         end
      end
   end
endmodule

// File: rtl/edge_irq_gpio.sv
`timescale 1ns/1ps
module edge_irq_gpio
   import eeg_pkg::*;
#(
   parameter int NUM_PINS    = 6,
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   output logic [NUM_PINS-1:0] pin_o,
   output logic [NUM_PINS-1:0] pin_oe,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [NUM_PINS-1:0] reg_wdata,
   output logic [NUM_PINS-1:0] reg_rdata,
   output logic                reg_rvalid,
   output logic                pm_irq_n,
   output logic                sm_irq_n
);
   if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_pins
      $error("edge_irq_gpio: NUM_PINS must lie in 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("edge_irq_gpio: SYNC_STAGES must be at least 2");
   end

   localparam logic [REG_AW-1:0] STS_ADDR [NUM_STS] = '{A_PMSTS, A_SMSTS, A_EVSTS};

   logic [NUM_PINS-1:0] sync_v;
   logic [NUM_PINS-1:0] edge_v;
   logic [NUM_PINS-1:0] mode, pol, dir, odrn, dout, pmen, smen;
   logic [NUM_PINS-1:0] sts [NUM_STS];
   logic [NUM_PINS-1:0] pm_sts, sm_sts, ev_sts;
   logic                pm_act, sm_act;
   logic [NUM_PINS-1:0] rd_mux;

   eeg_sync_edge #(
      .NUM_PINS    (NUM_PINS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_i),
      .sync_o (sync_v),
      .edge_o (edge_v)
   );

   eeg_ctrl_regs #(
      .NUM_PINS (NUM_PINS)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .mode  (mode),
      .pol   (pol),
      .dir   (dir),
      .odrn  (odrn),
      .dout  (dout),
      .pmen  (pmen),
      .smen  (smen)
   );

   for (genvar k = 0; k < NUM_STS; k++) begin : g_sts
      eeg_w1c #(
         .WIDTH (NUM_PINS)
      ) u_w1c (
         .clk      (clk),
         .rst_n    (rst_n),
         .set_i    (edge_v),
         .clr_we   (reg_wr && (reg_addr == STS_ADDR[k])),
         .clr_mask (reg_wdata),
         .q        (sts[k])
      );
   end

   assign pm_sts = sts[0];
   assign sm_sts = sts[1];
   assign ev_sts = sts[2];

   assign pm_act = |(pm_sts & pmen & mode);
   assign sm_act = |(sm_sts & smen & mode);

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pm_irq_n <= 1'b1;
            sm_irq_n <= 1'b1;
         end else begin
            pm_irq_n <= ~pm_act;
            sm_irq_n <= ~sm_act;
         end
      end
   end else begin : g_irq_comb
      assign pm_irq_n = ~pm_act;
      assign sm_irq_n = ~sm_act;
   end

   eeg_pad #(
      .NUM_PINS (NUM_PINS)
   ) u_pad (
      .mode   (mode),
      .pol    (pol),
      .dir    (dir),
      .odrn   (odrn),
      .dout   (dout),
      .pin_o  (pin_o),
      .pin_oe (pin_oe)
   );

   always_comb begin
      case (reg_addr)
         A_MODE:  rd_mux = mode;
         A_POL:   rd_mux = pol;
         A_DIR:   rd_mux = dir;
         A_ODRN:  rd_mux = odrn;
         A_DATA:  rd_mux = sync_v ^ pol;
         A_PMEN:  rd_mux = pmen;
         A_SMEN:  rd_mux = smen;
         A_PMSTS: rd_mux = pm_sts;
         A_SMSTS: rd_mux = sm_sts;
         A_EVSTS: rd_mux = ev_sts;
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata  <= '0;
         reg_rvalid <= 1'b0;
      end else begin
         reg_rvalid <= reg_rd;
         if (reg_rd) reg_rdata <= rd_mux;
      end
   end
endmodule

// File: rtl/edge_irq_gpio_chk.sv
`timescale 1ns/1ps
module edge_irq_gpio_chk
   import eeg_pkg::*;
#(
   parameter int NUM_PINS = 6,
   parameter bit IRQ_REG  = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] mode,
   input logic [NUM_PINS-1:0] pmen,
   input logic [NUM_PINS-1:0] smen,
   input logic [NUM_PINS-1:0] pm_sts,
   input logic [NUM_PINS-1:0] sm_sts,
   input logic [NUM_PINS-1:0] ev_sts,
   input logic [NUM_PINS-1:0] edge_v,
   input logic                reg_wr,
   input logic                reg_rd,
   input logic [REG_AW-1:0]   reg_addr,
   input logic [NUM_PINS-1:0] reg_wdata,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic                reg_rvalid,
   input logic                pm_irq_n,
   input logic                sm_irq_n
);
   logic pm_clr;
   assign pm_clr = reg_wr && (reg_addr == A_PMSTS);

   // R2: an edge sets the pin's bit in all three status registers
   p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_v != '0) |=> ((pm_sts & sm_sts & ev_sts & $past(edge_v)) == $past(edge_v)));

   // R3: a status bit only rises because of an edge
   p_rise_from_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr || !reg_wr) |=> ((pm_sts & ~$past(pm_sts) & ~$past(edge_v)) == '0));

   // R4: a write of ones clears those bits unless an edge arrives
   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pm_clr |=> ((pm_sts & $past(reg_wdata & ~edge_v)) == '0));

   // R4: without a clear write no bit falls
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !pm_clr |=> ((pm_sts & $past(pm_sts)) == $past(pm_sts)));

   // R5: set wins over a clear in the same cycle
   p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pm_clr && ((reg_wdata & edge_v) != '0))
         |=> ((pm_sts & $past(reg_wdata & edge_v)) == $past(reg_wdata & edge_v)));

   // R7: a dual-edge pin never drives
   p_input_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode & pin_oe) == '0));

   // R10: read data valid one cycle after the strobe
   p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> reg_rvalid);

   if (IRQ_REG) begin : g_irq_reg
      // R6: interrupt lines follow the gated status one cycle later
      p_pm_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr || !reg_wr) |=> (pm_irq_n == !$past(|(pm_sts & pmen & mode))));
      p_sm_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr || !reg_wr) |=> (sm_irq_n == !$past(|(sm_sts & smen & mode))));
   end else begin : g_irq_comb
      // R6: combinational variant
      p_pm_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (pm_irq_n == !(|(pm_sts & pmen & mode))));
      p_sm_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (sm_irq_n == !(|(sm_sts & smen & mode))));
   end
endmodule

bind edge_irq_gpio edge_irq_gpio_chk #(
   .NUM_PINS (NUM_PINS),
   .IRQ_REG  (IRQ_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode       (mode),
   .pmen       (pmen),
   .smen       (smen),
   .pm_sts     (pm_sts),
   .sm_sts     (sm_sts),
   .ev_sts     (ev_sts),
   .edge_v     (edge_v),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .pin_oe     (pin_oe),
   .reg_rvalid (reg_rvalid),
   .pm_irq_n   (pm_irq_n),
   .sm_irq_n   (sm_irq_n)
);

// File: tb/tb_edge_irq_gpio.sv
`timescale 1ns/1ps
module tb_edge_irq_gpio;
   localparam int N = 6;

   localparam logic [3:0] AD_MODE  = 4'd0;
   localparam logic [3:0] AD_POL   = 4'd1;
   localparam logic [3:0] AD_DIR   = 4'd2;
   localparam logic [3:0] AD_ODRN  = 4'd3;
   localparam logic [3:0] AD_DATA  = 4'd4;
   localparam logic [3:0] AD_PMEN  = 4'd5;
   localparam logic [3:0] AD_SMEN  = 4'd6;
   localparam logic [3:0] AD_PMSTS = 4'd7;
   localparam logic [3:0] AD_SMSTS = 4'd8;
   localparam logic [3:0] AD_EVSTS = 4'd9;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pins = '0;
   logic [N-1:0] pin_o, pin_oe;
   logic         reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]   reg_addr = '0;
   logic [N-1:0] reg_wdata = '0;
   logic [N-1:0] reg_rdata;
   logic         reg_rvalid;
   logic         pm_irq_n, sm_irq_n;

   int  tests = 0;
   int  fails = 0;
   bit  done  = 1'b0;

   typedef struct {
      logic [3:0]   a;
      logic [N-1:0] v;
      string        tag;
   } exp_t;
   exp_t sb_q[$];

   always #2 clk = ~clk;

   edge_irq_gpio #(.NUM_PINS(N)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (pins),
      .pin_o      (pin_o),
      .pin_oe     (pin_oe),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .reg_rvalid (reg_rvalid),
      .pm_irq_n   (pm_irq_n),
      .sm_irq_n   (sm_irq_n)
   );

   task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // driver: issue a read and push the expected value for the monitor
   task automatic rd(input logic [3:0] a, input logic [N-1:0] e, input string tag);
      exp_t item;
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      item.a = a; item.v = e; item.tag = tag;
      sb_q.push_back(item);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pin_to(input logic [N-1:0] v);
      @(negedge clk);
      pins = v;
      settle(5);
   endtask

   // monitor: pop an expected item for every valid read result
   always @(negedge clk) begin
      if (rst_n && reg_rvalid) begin
         if (sb_q.size() == 0) begin
            tests++;
            fails++;
            $display("FAIL R10: unexpected read data %b, expected none", reg_rdata);
         end else begin
            exp_t item;
            item = sb_q.pop_front();
            chk(reg_rdata, item.v, item.tag);
         end
      end
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      settle(4);
      rst_n = 1'b1;
      settle(1);

      // R1: reset state
      chk({5'd0, pm_irq_n}, 6'd1, "R1 pm_irq_n");
      chk({5'd0, sm_irq_n}, 6'd1, "R1 sm_irq_n");
      chk(pin_oe, '0, "R1 pin_oe");
      for (int a = 0; a < 10; a++) rd(4'(a), '0, "R1 register reset");

      // R10: control readback
      wr(AD_POL, 6'h2D);  rd(AD_POL, 6'h2D, "R10 pol");
      rd(AD_DATA, 6'h2D, "R9 inverted low pins");
      wr(AD_DIR, 6'h13);  rd(AD_DIR, 6'h13, "R10 dir");
      wr(AD_ODRN, 6'h21); rd(AD_ODRN, 6'h21, "R10 odrn");
      wr(AD_DATA, 6'h0C);
      wr(AD_PMEN, 6'h3F); rd(AD_PMEN, 6'h3F, "R10 pmen");
      wr(AD_SMEN, 6'h2A); rd(AD_SMEN, 6'h2A, "R10 smen");
      wr(AD_MODE, 6'h15); rd(AD_MODE, 6'h15, "R10 mode");
      wr(AD_POL, '0); wr(AD_DIR, '0); wr(AD_ODRN, '0); wr(AD_DATA, '0);
      wr(AD_PMEN, '0); wr(AD_SMEN, '0); wr(AD_MODE, '0);

      // R2, R3: rising edge with mode and enables off
      pin_to(6'b000001);
      rd(AD_PMSTS, 6'b000001, "R3 pm rise");
      rd(AD_SMSTS, 6'b000001, "R3 sm rise");
      rd(AD_EVSTS, 6'b000001, "R2 ev rise");
      chk({5'd0, pm_irq_n}, 6'd1, "R6 no enable");
      wr(AD_PMSTS, 6'h01); wr(AD_SMSTS, 6'h01); wr(AD_EVSTS, 6'h01);
      rd(AD_PMSTS, '0, "R4 pm cleared");
      rd(AD_EVSTS, '0, "R4 ev cleared");
      // R2: falling edge
      pin_to(6'b000000);
      rd(AD_PMSTS, 6'b000001, "R2 pm fall");
      rd(AD_SMSTS, 6'b000001, "R2 sm fall");
      rd(AD_EVSTS, 6'b000001, "R2 ev fall");

      // R4: zero writes and independence
      wr(AD_PMSTS, 6'h00); rd(AD_PMSTS, 6'h01, "R4 zero write");
      wr(AD_PMSTS, 6'h3E); rd(AD_PMSTS, 6'h01, "R4 other bits");
      wr(AD_PMSTS, 6'h01); rd(AD_PMSTS, 6'h00, "R4 clear bit");
      rd(AD_SMSTS, 6'h01, "R4 sm untouched");
      wr(AD_SMSTS, 6'h3F); wr(AD_EVSTS, 6'h3F);

      // R2: two pins together
      pin_to(6'b101000);
      rd(AD_EVSTS, 6'b101000, "R2 two pins");
      wr(AD_PMSTS, 6'h3F); wr(AD_SMSTS, 6'h3F); wr(AD_EVSTS, 6'h3F);

      // R6: interrupt gating
      wr(AD_PMEN, 6'h01);
      pin_to(6'b101001);
      chk({5'd0, pm_irq_n}, 6'd1, "R6 mode off");
      wr(AD_MODE, 6'h01); settle(2);
      chk({5'd0, pm_irq_n}, 6'd0, "R6 pm asserted");
      chk({5'd0, sm_irq_n}, 6'd1, "R6 sm not enabled");
      wr(AD_SMEN, 6'h01); settle(2);
      chk({5'd0, sm_irq_n}, 6'd0, "R6 sm asserted");
      wr(AD_PMSTS, 6'h01); settle(2);
      chk({5'd0, pm_irq_n}, 6'd1, "R6 pm released");
      chk({5'd0, sm_irq_n}, 6'd0, "R6 sm still low");
      wr(AD_SMSTS, 6'h01); settle(2);
      chk({5'd0, sm_irq_n}, 6'd1, "R6 sm released");
      wr(AD_EVSTS, 6'h3F);
      wr(AD_PMEN, '0); wr(AD_SMEN, '0); wr(AD_MODE, '0);

      // R5: edge and clear land on the same cycle
      @(negedge clk); pins[4] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = AD_PMSTS; reg_wdata = 6'h3F;
      @(negedge clk);
      reg_wr = 1'b0;
      rd(AD_PMSTS, 6'b010000, "R5 set wins");
      wr(AD_PMSTS, 6'h3F); wr(AD_SMSTS, 6'h3F); wr(AD_EVSTS, 6'h3F);

      // R7: dual-edge pins never drive
      wr(AD_MODE, 6'h3F); wr(AD_DIR, 6'h3F); wr(AD_DATA, 6'h3F);
      chk(pin_oe, '0, "R7 push-pull");
      wr(AD_ODRN, 6'h3F);
      chk(pin_oe, '0, "R7 open-drain");
      wr(AD_POL, 6'h3F);
      chk(pin_oe, '0, "R7 inverted");
      // R9: inversion still applies in dual-edge mode (pins 111001)
      rd(AD_DATA, 6'b000110, "R9 dual-edge inverted");
      wr(AD_MODE, '0); wr(AD_DIR, '0); wr(AD_ODRN, '0);
      wr(AD_POL, '0); wr(AD_DATA, '0);

      // R8: normal-mode drive
      wr(AD_DATA, 6'b000110); wr(AD_ODRN, 6'b000100); wr(AD_DIR, 6'b000110);
      chk(pin_oe, 6'b000010, "R8 od high released");
      chk(pin_o & pin_oe, 6'b000010, "R8 pp high");
      wr(AD_DATA, 6'b000000);
      chk(pin_oe, 6'b000110, "R8 od low drives");
      chk(pin_o & pin_oe, 6'b000000, "R8 levels low");
      wr(AD_POL, 6'b000010);
      chk(pin_oe, 6'b000110, "R8 inverted enables");
      chk(pin_o & pin_oe, 6'b000010, "R8 inverted level");

      // R9: normal-mode readback
      wr(AD_POL, 6'b000001);
      pin_to(6'b100101);
      rd(AD_DATA, 6'b100100, "R9 normal inverted");

      settle(3);
      if (sb_q.size() != 0) begin
         tests++;
         fails++;
         $display("FAIL R10: actual %0d reads pending expected 0", sb_q.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule